// File: doc/BRIEF.md
# Bit-Field Insert Unit

This execution unit places a right-aligned field taken from a source operand into a selected bit range of a destination operand's current value. Every destination bit outside that range keeps its old value. The field is described by two 5-bit positions, counted from the least significant bit. The low position gives the first bit of the range, and the high position gives the last bit. The field width is therefore the high position minus the low position plus one.

The selection mask is built as the XOR of two all-ones words. One is shifted left by the high position plus one, and the other is shifted left by the low position. When the high position is the top bit, the first term is forced to zero.

An operation is presented with `op_valid` together with a 6-bit primary opcode. Only the field-insert opcode is accepted. A single register stage holds the mask, the merged word and an illegal-field flag. These appear one cycle later, qualified by `result_valid`. A high position below the low position is an illegal encoding. In that case the destination is passed through unchanged and the flag is raised.

Top module: `bfins_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `result_valid`, `result`, `mask_out` and `bad_field` are all zero.
- R2: When `op_valid` is high and `opcode` equals 6'b011001 at a rising clock edge, `result_valid` is high during the following cycle. It is low after any edge at which no such operation was presented.
- R3: An operation whose `opcode` is not 6'b011001 is ignored. `result_valid` stays low, and `result`, `mask_out` and `bad_field` keep their previous values.
- R4: For a legal operation (`hi_pos` >= `lo_pos`), bit i of `mask_out`, counted from the LSB as bit 0, is 1 exactly when `lo_pos` <= i <= `hi_pos`.
- R5: When `hi_pos` is 31, the mask covers every bit from `lo_pos` through bit 31. This includes the full-word case with `lo_pos` = 0.
- R6: For a legal operation, `result` bit i equals `src_val` bit (i - `lo_pos`) inside the mask and equals `dst_old` bit i outside it.
- R7: Bits of `src_val` at or above the field width never reach `result`. The shift fills the vacated low bits with zeros.
- R8: When `hi_pos` < `lo_pos`, `result` equals `dst_old`, `mask_out` is zero and `bad_field` is 1. For a legal operation, `bad_field` is 0.
- R9: When no accepted operation occurs, `result`, `mask_out` and `bad_field` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| opcode | input | 6 | Primary opcode; only 6'b011001 is accepted |
| src_val | input | 32 | Source word; its low bits form the field |
| dst_old | input | 32 | Current destination value |
| lo_pos | input | 5 | Index of the field's first (lowest) bit |
| hi_pos | input | 5 | Index of the field's last (highest) bit |
| result_valid | output | 1 | Registered outputs belong to the operation of the previous cycle |
| result | output | 32 | Merged destination word |
| mask_out | output | 32 | Selected bit range |
| bad_field | output | 1 | High position was below low position |

## Verification
The insert path is driven with fields at the bottom, in the middle and at the top of the word. It is also driven with single-bit fields at bit 4 and bit 31, and with the full 32-bit field. These cases separate an off-by-one in either shift amount, and they show whether the shift by 32 is zeroed. Sources with ones above the field width show whether unmasked source bits leak into the result. Destinations of all ones and of mixed patterns show whether untouched bits are lost. A reversed range, a foreign opcode and idle cycles distinguish pass-through and flagging from simple inactivity.

// File: rtl/bfins_pkg.sv
package bfins_pkg;
    localparam int OPCODE_W = 6;
    localparam logic [OPCODE_W-1:0] OPC_FIELD_INSERT = 6'b011001;
endpackage

// File: rtl/bfins_mask_gen.sv
module bfins_mask_gen #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic [POS_W-1:0]  lo_pos,
    input  logic [POS_W-1:0]  hi_pos,
    output logic [DATA_W-1:0] mask,
    output logic              legal
);
    localparam logic [POS_W-1:0] TOP_IDX = POS_W'(DATA_W - 1);
    localparam logic [POS_W-1:0] ONE_POS = POS_W'(1);

    logic [DATA_W-1:0] upper_ones;
    logic [DATA_W-1:0] lower_ones;

    always_comb begin
        // A shift by the full word width must give zero, so the top index is special
        if (hi_pos == TOP_IDX) begin
            upper_ones = '0;
        end else begin
            upper_ones = {DATA_W{1'b1}} << (hi_pos + ONE_POS);
        end
        lower_ones = {DATA_W{1'b1}} << lo_pos;
        legal      = (hi_pos >= lo_pos);
        mask       = legal ? (upper_ones ^ lower_ones) : '0;
    end
endmodule

// File: rtl/bfins_merge.sv
module bfins_merge #(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] dst_old,
    input  logic [POS_W-1:0]  lo_pos,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] aligned;

    always_comb begin
        aligned = src_val << lo_pos;
    end

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
        assign merged[gi] = mask[gi] ? aligned[gi] : dst_old[gi];
    end
endmodule

// File: rtl/bfins_unit.sv
module bfins_unit
    import bfins_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [OPCODE_W-1:0] opcode,
    input  logic [DATA_W-1:0]   src_val,
    input  logic [DATA_W-1:0]   dst_old,
    input  logic [POS_W-1:0]    lo_pos,
    input  logic [POS_W-1:0]    hi_pos,
    output logic                result_valid,
    output logic [DATA_W-1:0]   result,
    output logic [DATA_W-1:0]   mask_out,
    output logic                bad_field
);
    typedef struct packed {
        logic              vld;
        logic              bad;
        logic [DATA_W-1:0] msk;
        logic [DATA_W-1:0] res;
    } out_stage_t;

    out_stage_t        stage_d, stage_q;
    logic [DATA_W-1:0] sel_mask;
    logic [DATA_W-1:0] merged_word;
    logic              range_legal;
    logic              accept;

    bfins_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W)) u_mask (
        .lo_pos (lo_pos),
        .hi_pos (hi_pos),
        .mask   (sel_mask),
        .legal  (range_legal)
    );

    bfins_merge #(.DATA_W(DATA_W), .POS_W(POS_W)) u_merge (
        .src_val (src_val),
        .dst_old (dst_old),
        .lo_pos  (lo_pos),
        .mask    (sel_mask),
        .merged  (merged_word)
    );

    always_comb begin
        accept      = op_valid && (opcode == OPC_FIELD_INSERT);
        stage_d     = stage_q;
        stage_d.vld = accept;
        if (accept) begin
            stage_d.bad = !range_legal;
            stage_d.msk = sel_mask;
            stage_d.res = merged_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign result_valid = stage_q.vld;
    assign bad_field    = stage_q.bad;
    assign mask_out     = stage_q.msk;
    assign result       = stage_q.res;
endmodule

// File: rtl/bfins_checker.sv
module bfins_checker
    import bfins_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic [OPCODE_W-1:0] opcode,
    input logic [DATA_W-1:0]   src_val,
    input logic [DATA_W-1:0]   dst_old,
    input logic [POS_W-1:0]    lo_pos,
    input logic [POS_W-1:0]    hi_pos,
    input logic                result_valid,
    input logic [DATA_W-1:0]   result,
    input logic [DATA_W-1:0]   mask_out,
    input logic                bad_field
);
    logic [DATA_W-1:0] low_one;
    assign low_one = mask_out & (~mask_out + DATA_W'(1));

    // R2: an accepted operation yields a valid result next cycle
    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OPC_FIELD_INSERT) |=> result_valid);

    // R3 and R9: no accepted operation leaves the outputs unchanged
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && opcode == OPC_FIELD_INSERT) |=>
            (!result_valid && $stable(result) && $stable(mask_out) && $stable(bad_field)));

    // R8: a reversed range passes the destination through
    p_bad_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && bad_field) |-> (result == $past(dst_old) && mask_out == '0));

    // R6: bits outside the mask come from the old destination
    p_outside_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !bad_field) |-> (((result ^ $past(dst_old)) & ~mask_out) == '0));

    // R4: a legal mask is one non-empty contiguous run
    p_mask_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !bad_field) |->
            (mask_out != '0 && ((mask_out + low_one) & mask_out) == '0));

    // R4: the lowest set mask bit sits at the low position
    p_mask_base_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !bad_field) |-> (low_one == (DATA_W'(1) << $past(lo_pos))));
endmodule

bind bfins_unit bfins_checker #(.DATA_W(DATA_W), .POS_W(POS_W)) u_bfins_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .opcode       (opcode),
    .src_val      (src_val),
    .dst_old      (dst_old),
    .lo_pos       (lo_pos),
    .hi_pos       (hi_pos),
    .result_valid (result_valid),
    .result       (result),
    .mask_out     (mask_out),
    .bad_field    (bad_field)
);

// File: tb/bfins_unit_bench.sv
`timescale 1ns/1ps
module bfins_unit_bench;
    localparam int NV = 8;
    localparam logic [5:0] OPC_OK  = 6'b011001;
    localparam logic [5:0] OPC_BAD = 6'b100000;

    // stimulus and expected mask; expected result is computed per bit below
    localparam logic [31:0] T_SRC  [NV] = '{32'h0000_00A5, 32'h1234_5678, 32'hFFFF_FFFF, 32'hDEAD_BEEF,
                                            32'h0000_C3C3, 32'h0000_0001, 32'h0000_0155, 32'h0000_00FF};
    localparam logic [31:0] T_DST  [NV] = '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h5555_5555,
                                            32'hAAAA_AAAA, 32'h0F0F_0F0F, 32'hFFFF_0000, 32'h1357_9BDF};
    localparam logic [4:0]  T_LO   [NV] = '{5'd0, 5'd8, 5'd4, 5'd0, 5'd16, 5'd31, 5'd3, 5'd12};
    localparam logic [4:0]  T_HI   [NV] = '{5'd7, 5'd15, 5'd4, 5'd31, 5'd31, 5'd31, 5'd10, 5'd19};
    localparam logic [31:0] T_MASK [NV] = '{32'h0000_00FF, 32'h0000_FF00, 32'h0000_0010, 32'hFFFF_FFFF,
                                            32'hFFFF_0000, 32'h8000_0000, 32'h0000_07F8, 32'h000F_F000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] src_val = '0;
    logic [31:0] dst_old = '0;
    logic [4:0]  lo_pos = '0;
    logic [4:0]  hi_pos = '0;
    logic        result_valid;
    logic [31:0] result;
    logic [31:0] mask_out;
    logic        bad_field;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bfins_unit u_bfins_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .src_val(src_val), .dst_old(dst_old), .lo_pos(lo_pos), .hi_pos(hi_pos),
        .result_valid(result_valid), .result(result), .mask_out(mask_out), .bad_field(bad_field)
    );

    function automatic logic [31:0] ref_insert(logic [31:0] s, logic [31:0] d, int lo, int hi);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            r[i] = (i >= lo && i <= hi) ? s[i - lo] : d[i];
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(logic [5:0] opc, logic [31:0] s, logic [31:0] d, logic [4:0] lo, logic [4:0] hi);
        @(negedge clk);
        op_valid = 1'b1; opcode = opc; src_val = s; dst_old = d; lo_pos = lo; hi_pos = hi;
        @(negedge clk);
        op_valid = 1'b0; opcode = '0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [31:0] keep_res;
        logic [31:0] keep_msk;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid in reset", {31'b0, result_valid}, 32'h0);
        chk("R1 result in reset", result, 32'h0);
        chk("R1 mask in reset", mask_out, 32'h0);
        chk("R1 flag in reset", {31'b0, bad_field}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {31'b0, result_valid}, 32'h0);

        // table walk: R2 R4 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            issue(OPC_OK, T_SRC[k], T_DST[k], T_LO[k], T_HI[k]);
            chk("R2 valid", {31'b0, result_valid}, 32'h1);
            chk("R4 R5 mask", mask_out, T_MASK[k]);
            chk("R6 result", result, ref_insert(T_SRC[k], T_DST[k], T_LO[k], T_HI[k]));
            chk("R8 flag clear on legal", {31'b0, bad_field}, 32'h0);
        end

        // R7: source bits above field width must not leak
        issue(OPC_OK, 32'hFFFF_FFFF, 32'h0000_0000, 5'd8, 5'd11);
        chk("R7 upper source bits dropped", result, 32'h0000_0F00);

        // R8: reversed range
        issue(OPC_OK, 32'hFFFF_FFFF, 32'h2468_ACE0, 5'd10, 5'd3);
        chk("R8 passthrough", result, 32'h2468_ACE0);
        chk("R8 mask zero", mask_out, 32'h0);
        chk("R8 flag set", {31'b0, bad_field}, 32'h1);
        chk("R8 valid", {31'b0, result_valid}, 32'h1);

        // legal op to set a known state, then foreign opcode (R3)
        issue(OPC_OK, 32'h0000_000F, 32'h0000_0000, 5'd4, 5'd7);
        keep_res = result; keep_msk = mask_out;
        chk("R6 state before ignore", keep_res, 32'h0000_00F0);
        issue(OPC_BAD, 32'hFFFF_FFFF, 32'h1111_1111, 5'd9, 5'd2);
        chk("R3 valid low", {31'b0, result_valid}, 32'h0);
        chk("R3 result held", result, keep_res);
        chk("R3 mask held", mask_out, keep_msk);
        chk("R3 flag held", {31'b0, bad_field}, 32'h0);

        // R9: idle cycles hold outputs
        @(negedge clk);
        @(negedge clk);
        chk("R9 valid low idle", {31'b0, result_valid}, 32'h0);
        chk("R9 result held idle", result, keep_res);

        // R1: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 result cleared", result, 32'h0);
        chk("R1 mask cleared", mask_out, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end
endmodule